// File: doc/BRIEF.md
# Tiled Address Bit-6 Swizzler

This unit rewrites a linear byte address inside a tiled surface into the address that the memory system actually decodes. It leaves every bit alone except bit 6, which it XORs with a chosen set of higher address bits. Which bits are folded in depends on two things. The first is the memory-channel configuration, latched from a configuration word when a load strobe is pulsed. The second is the tiling layout of the current access: linear, X-major or Y-major.

A controller loads a configuration word once, or whenever the memory arrangement changes. The word carries an addressing mode, a channel-XOR disable flag, a high-bit select flag and two channel size fields. A separate input selects which rule derives the swizzle from the word. One rule decodes the interleave fields. The other compares the two channel sizes. From then on the address path is purely combinational. Every access presents an address and a tiling layout and receives, in the same cycle:
- the swizzled address;
- the effective tiling layout;
- the reported swizzle code.

The reported code never shows bit-17 involvement, but the address itself is still corrected for bit 17.

A small controller tracks the configuration with three states:
- `ST_BLANK`: after reset, no swizzle.
- `ST_ACTIVE`: a usable configuration has been loaded.
- `ST_UNKNOWN`: the loaded word was all ones.

Its transitions are:
- `LOAD_OK`: any state to `ST_ACTIVE` on a strobe whose word is not all ones.
- `LOAD_BAD`: any state to `ST_UNKNOWN` on a strobe whose word is all ones.
- `HOLD`: no strobe, the state is unchanged.

Top module: `tiled_bit6_swizzler`

## Requirements
- R1: After reset, before any load, both stored swizzle codes are none (0), `mode_rpt` is 0 and `addr_out` equals `addr_in` for every tiling layout.
- R2: Tiling code 0 (linear) and the reserved code 3 are never swizzled: `addr_out` equals `addr_in`, `tile_eff` is 0 and `mode_rpt` is 0 (none).
- R3: With the base swizzle, X tiling (code 1) replaces bit 6 with bit6^bit9^bit10 and reports 2. Y tiling (code 2) replaces bit 6 with bit6^bit9 and reports 1.
- R4: In the interleave rule (`cfg_by_size`=0), the addressing field `cfg_word[1:0]` values 0 (single channel), 1 (asymmetric dual) and 3 (reserved) give no swizzle for either layout.
- R5: Addressing field 2 (interleaved dual) with `cfg_word[2]`=1 (channel XOR disabled) gives the base swizzle of R3.
- R6: Addressing field 2 with `cfg_word[2]`=0 and `cfg_word[3]`=0 also folds in bit 11. X reports 4 (9_10_11) and Y reports 3 (9_11).
- R7: Addressing field 2 with `cfg_word[2]`=0 and `cfg_word[3]`=1 folds in bit 17 instead. The report hides it: X reports 2 and Y reports 1, never 5 or 6.
- R8: In the size rule (`cfg_by_size`=1), equal size fields `cfg_word[4+:SIZE_W]` and `cfg_word[4+SIZE_W+:SIZE_W]` give the base swizzle of R3. Unequal fields give none.
- R9: A loaded word of all ones makes the swizzle unknown (stored code 7). Every access then has `tile_eff`=0, `mode_rpt`=0 and `addr_out`=`addr_in`.
- R10: No address bit other than bit 6 ever differs between `addr_in` and `addr_out`.
- R11: A new configuration takes effect from the cycle after the clock edge that samples `cfg_load`=1. Changing `cfg_word` or `cfg_by_size` without the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Strobe that latches the configuration |
| cfg_by_size | input | 1 | 1 selects the size-compare rule, 0 the interleave rule |
| cfg_word | input | 4+2*SIZE_W | Configuration: [1:0] addressing, [2] XOR disable, [3] high-bit select, then two size fields |
| addr_in | input | AW | Linear byte address |
| tile_in | input | 2 | Tiling layout: 0 linear, 1 X, 2 Y, 3 reserved |
| addr_out | output | AW | Swizzled byte address |
| tile_eff | output | 2 | Effective tiling layout after forcing |
| mode_rpt | output | 3 | Reported swizzle code, bit-17 variants hidden |

## Verification
On every cycle the assertions check four things. Linear and reserved accesses pass through untouched. Only bit 6 can change. The report never exposes a bit-17 or unknown code. The unknown state always forces the layout to linear. Two further checks tie the stored codes to the strobe: they hold without one and follow the decoder after one. Which higher bits are folded in for each combination of rule, fields and layout cannot be seen by those properties. Only the bench's directed configurations and random addresses, compared against its own model, show that mapping. The same applies to whether ignored fields really are ignored.

// File: rtl/swz_pkg.sv
package swz_pkg;

    typedef enum logic [2:0] {
        SWZ_NONE     = 3'd0,
        SWZ_9        = 3'd1,
        SWZ_9_10     = 3'd2,
        SWZ_9_11     = 3'd3,
        SWZ_9_10_11  = 3'd4,
        SWZ_9_17     = 3'd5,
        SWZ_9_10_17  = 3'd6,
        SWZ_UNKNOWN  = 3'd7
    } swz_mode_e;

    typedef enum logic [1:0] {
        TILE_LINEAR = 2'd0,
        TILE_X      = 2'd1,
        TILE_Y      = 2'd2,
        TILE_RSVD   = 2'd3
    } tile_e;

    typedef enum logic [1:0] {
        AM_SINGLE = 2'd0,
        AM_ASYM   = 2'd1,
        AM_INTLV  = 2'd2,
        AM_RSVD   = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_BLANK   = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_UNKNOWN = 2'd2
    } cfg_state_e;

    localparam int BIT_SWZ = 6;

endpackage

// File: rtl/swz_mode_decode.sv
module swz_mode_decode
    import swz_pkg::*;
#(
    parameter int SIZE_W = 8
) (
    input  logic                  by_size,
    input  logic [4+2*SIZE_W-1:0] word,
    output swz_mode_e             mode_x,
    output swz_mode_e             mode_y,
    output logic                  word_bad
);
    localparam int CW = 4 + 2 * SIZE_W;

    addr_mode_e         am;
    logic               xor_off;
    logic               hi_sel;
    logic [SIZE_W-1:0]  size_a;
    logic [SIZE_W-1:0]  size_b;

    assign am      = addr_mode_e'(word[1:0]);
    assign xor_off = word[2];
    assign hi_sel  = word[3];
    assign size_a  = word[4 +: SIZE_W];
    assign size_b  = word[4+SIZE_W +: SIZE_W];
    assign word_bad = (word == {CW{1'b1}});

    always_comb begin
        mode_x = SWZ_NONE;
        mode_y = SWZ_NONE;
        if (word_bad) begin
            mode_x = SWZ_UNKNOWN;
            mode_y = SWZ_UNKNOWN;
        end else if (by_size) begin
            if (size_a == size_b) begin
                mode_x = SWZ_9_10;
                mode_y = SWZ_9;
            end
        end else begin
            unique case (am)
                AM_INTLV: begin
                    if (xor_off) begin
                        mode_x = SWZ_9_10;
                        mode_y = SWZ_9;
                    end else if (!hi_sel) begin
                        mode_x = SWZ_9_10_11;
                        mode_y = SWZ_9_11;
                    end else begin
                        mode_x = SWZ_9_10_17;
                        mode_y = SWZ_9_17;
                    end
                end
                default: begin
                    mode_x = SWZ_NONE;
                    mode_y = SWZ_NONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/swz_cfg_ctrl.sv
module swz_cfg_ctrl
    import swz_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      word_bad,
    input  swz_mode_e next_x,
    input  swz_mode_e next_y,
    output swz_mode_e mode_x,
    output swz_mode_e mode_y,
    output logic      cfg_unknown
);
    cfg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK, ST_ACTIVE, ST_UNKNOWN: begin
                if (load) state_d = word_bad ? ST_UNKNOWN : ST_ACTIVE;
            end
            default: state_d = ST_BLANK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_x <= SWZ_NONE;
            mode_y <= SWZ_NONE;
        end else if (load) begin
            mode_x <= next_x;
            mode_y <= next_y;
        end
    end

    assign cfg_unknown = (state_q == ST_UNKNOWN);

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(mode_x) && $stable(mode_y)));                 // R11
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mode_x == $past(next_x) && mode_y == $past(next_y)));  // R11
    AST_STATE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_unknown == (mode_x == SWZ_UNKNOWN));                         // R9

endmodule

// File: rtl/swz_addr_path.sv
module swz_addr_path
    import swz_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_in,
    input  logic [1:0]    tile_in,
    input  swz_mode_e     mode_x,
    input  swz_mode_e     mode_y,
    input  logic          cfg_unknown,
    output logic [AW-1:0] addr_out,
    output logic [1:0]    tile_eff,
    output logic [2:0]    mode_rpt
);
    swz_mode_e sel;
    swz_mode_e rpt;
    logic      flip;
    logic      b9, b10, b11, b17;

    assign b9  = addr_in[9];
    assign b10 = addr_in[10];
    assign b11 = addr_in[11];
    assign b17 = addr_in[17];

    always_comb begin
        unique case (tile_e'(tile_in))
            TILE_X:  sel = mode_x;
            TILE_Y:  sel = mode_y;
            default: sel = SWZ_NONE;
        endcase
    end

    always_comb begin
        flip     = 1'b0;
        rpt      = sel;
        tile_eff = (tile_in == TILE_RSVD) ? TILE_LINEAR : tile_in;
        unique case (sel)
            SWZ_9:       flip = b9;
            SWZ_9_10:    flip = b9 ^ b10;
            SWZ_9_11:    flip = b9 ^ b11;
            SWZ_9_10_11: flip = b9 ^ b10 ^ b11;
            SWZ_9_17:    begin flip = b9 ^ b17;       rpt = SWZ_9;    end
            SWZ_9_10_17: begin flip = b9 ^ b10 ^ b17; rpt = SWZ_9_10; end
            default:     flip = 1'b0;
        endcase
        if (cfg_unknown) begin
            flip     = 1'b0;
            rpt      = SWZ_NONE;
            tile_eff = TILE_LINEAR;
        end
    end

    always_comb begin
        addr_out          = addr_in;
        addr_out[BIT_SWZ] = addr_in[BIT_SWZ] ^ flip;
    end

    assign mode_rpt = rpt;

    AST_UNTILED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_in == TILE_LINEAR || tile_in == TILE_RSVD) |-> (addr_out == addr_in && mode_rpt == 3'd0)); // R2
    AST_ONLY_BIT6: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_out ^ addr_in) & ~(AW'(1) << BIT_SWZ)) == '0);             // R10
    AST_NO_HIGH_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rpt != 3'd5 && mode_rpt != 3'd6 && mode_rpt != 3'd7);       // R7
    AST_UNKNOWN_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_unknown |-> (tile_eff == 2'd0 && addr_out == addr_in));      // R9

endmodule

// File: rtl/tiled_bit6_swizzler.sv
module tiled_bit6_swizzler
    import swz_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SIZE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_load,
    input  logic                  cfg_by_size,
    input  logic [4+2*SIZE_W-1:0] cfg_word,
    input  logic [AW-1:0]         addr_in,
    input  logic [1:0]            tile_in,
    output logic [AW-1:0]         addr_out,
    output logic [1:0]            tile_eff,
    output logic [2:0]            mode_rpt
);
    swz_mode_e dec_x, dec_y, cur_x, cur_y;
    logic      word_bad;
    logic      cfg_unknown;

    swz_mode_decode #(.SIZE_W(SIZE_W)) u_dec (
        .by_size (cfg_by_size),
        .word    (cfg_word),
        .mode_x  (dec_x),
        .mode_y  (dec_y),
        .word_bad(word_bad)
    );

    swz_cfg_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .word_bad   (word_bad),
        .next_x     (dec_x),
        .next_y     (dec_y),
        .mode_x     (cur_x),
        .mode_y     (cur_y),
        .cfg_unknown(cfg_unknown)
    );

    swz_addr_path #(.AW(AW)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_in    (addr_in),
        .tile_in    (tile_in),
        .mode_x     (cur_x),
        .mode_y     (cur_y),
        .cfg_unknown(cfg_unknown),
        .addr_out   (addr_out),
        .tile_eff   (tile_eff),
        .mode_rpt   (mode_rpt)
    );

endmodule

// File: tb/tb_tiled_bit6_swizzler.sv
module tb_tiled_bit6_swizzler;
    localparam int AW = 32;
    localparam int SW = 8;
    localparam int CW = 4 + 2 * SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic          cfg_by_size = 1'b0;
    logic [CW-1:0] cfg_word = '0;
    logic [AW-1:0] addr_in = '0;
    logic [1:0]    tile_in = 2'd0;
    logic [AW-1:0] addr_out;
    logic [1:0]    tile_eff;
    logic [2:0]    mode_rpt;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [2:0] mdl_x = 3'd0, mdl_y = 3'd0;

    always #2.5 clk = ~clk;

    tiled_bit6_swizzler #(.AW(AW), .SIZE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_by_size(cfg_by_size),
        .cfg_word(cfg_word), .addr_in(addr_in), .tile_in(tile_in),
        .addr_out(addr_out), .tile_eff(tile_eff), .mode_rpt(mode_rpt)
    );

    function automatic logic [2:0] ref_mode(input logic by, input logic [CW-1:0] w, input logic is_y);
        if (&w) return 3'd7;
        if (by) return (w[4 +: SW] == w[4+SW +: SW]) ? (is_y ? 3'd1 : 3'd2) : 3'd0;
        if (w[1:0] != 2'd2) return 3'd0;
        if (w[2]) return is_y ? 3'd1 : 3'd2;
        if (!w[3]) return is_y ? 3'd3 : 3'd4;
        return is_y ? 3'd5 : 3'd6;
    endfunction

    function automatic logic ref_flip(input logic [2:0] m, input logic [AW-1:0] a);
        case (m)
            3'd1: return a[9];
            3'd2: return a[9] ^ a[10];
            3'd3: return a[9] ^ a[11];
            3'd4: return a[9] ^ a[10] ^ a[11];
            3'd5: return a[9] ^ a[17];
            3'd6: return a[9] ^ a[10] ^ a[17];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic by, input logic [CW-1:0] w);
        @(negedge clk);
        cfg_by_size = by;
        cfg_word    = w;
        cfg_load    = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        mdl_x = ref_mode(by, w, 1'b0);
        mdl_y = ref_mode(by, w, 1'b1);
    endtask

    task automatic access(input string req, input logic [AW-1:0] a, input logic [1:0] t);
        logic [2:0]    m;
        logic [AW-1:0] ea;
        logic [1:0]    et;
        logic [2:0]    er;
        addr_in = a;
        tile_in = t;
        #1;
        m  = (t == 2'd1) ? mdl_x : (t == 2'd2) ? mdl_y : 3'd0;
        ea = a;
        et = (t == 2'd3) ? 2'd0 : t;
        er = m;
        if (m == 3'd7) begin
            et = 2'd0; er = 3'd0;
        end else begin
            ea[6] = a[6] ^ ref_flip(m, a);
            if (m == 3'd5) er = 3'd1;
            if (m == 3'd6) er = 3'd2;
        end
        check({req, " addr"}, addr_out, ea);
        check({req, " tile"}, AW'(tile_eff), AW'(et));
        check({req, " mode"}, AW'(mode_rpt), AW'(er));
    endtask

    task automatic sweep(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            access(req, $urandom, 2'($urandom));
        end
        access(req, 32'h0000_0600, 2'd1);
        access(req, 32'h0002_0a40, 2'd2);
        access(req, 32'h0002_0e00, 2'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        access("R1", 32'h0000_0640, 2'd1);
        access("R1", 32'h0002_0e40, 2'd2);
        // R3 / R5 base swizzle from interleave with XOR disabled
        load_cfg(1'b0, CW'('b0110));
        sweep("R5", 40);
        access("R3", 32'h0000_0200, 2'd1);
        access("R3", 32'h0000_0400, 2'd2);
        // R2 untiled and reserved layouts
        for (int i = 0; i < 30; i++) begin
            access("R2", $urandom, 2'd0);
            access("R2", $urandom, 2'd3);
        end
        // R4 non-interleaved addressing modes
        load_cfg(1'b0, CW'('b0000));
        sweep("R4", 20);
        load_cfg(1'b0, CW'('b0001));
        sweep("R4", 20);
        load_cfg(1'b0, CW'('b1011));
        sweep("R4", 20);
        // R6 bit-11 folding
        load_cfg(1'b0, CW'('b0010));
        sweep("R6", 40);
        // R7 bit-17 folding, hidden in report
        load_cfg(1'b0, CW'('b1010));
        sweep("R7", 40);
        // R11 change without strobe has no effect
        @(negedge clk);
        cfg_word = CW'('b0000);
        cfg_by_size = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sweep("R11", 20);
        // R8 size compare
        load_cfg(1'b1, {8'h40, 8'h40, 4'b0000});
        sweep("R8", 30);
        load_cfg(1'b1, {8'h40, 8'h20, 4'b0010});
        sweep("R8", 30);
        // R9 all-ones word
        load_cfg(1'b1, {CW{1'b1}});
        sweep("R9", 30);
        load_cfg(1'b0, {CW{1'b1}});
        sweep("R9", 10);
        // R11 recovery after strobe; R10 random across configs
        load_cfg(1'b0, CW'('b0010));
        sweep("R11", 10);
        for (int k = 0; k < 20; k++) begin
            load_cfg(1'($urandom), CW'($urandom));
            sweep("R10", 20);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule